// File: doc/BRIEF.md
# Translation Fault Event Mapper

This block sits at the end of an address-translation pipeline. For each translation attempt it takes the outcome and produces two results: the access permission handed back to the requester, and at most one fault event for the event queue. The outcome is made up of the unit enable, the configuration-stage result (an aborted flag and a fault code), the page-walk error class with the walk address, the request address and access flags, and the per-context record-faults control.

Both results come out registered, one cycle after `in_valid`. A disabled unit lets the request through untouched. An aborted configuration denies the request silently. A configuration fault denies the request and reports its own code. Page-walk errors are then mapped to event codes. An external abort during the walk is always reported and carries a class and a second address. The four ordinary walk faults are reported only when record-faults is set. Page walking, configuration decoding and the event queue are outside this block.

Top module: `tfem_fault_mapper`

## Requirements
- R1: With `unit_en` low, `out_perm` equals `req_flags` and `evt_push` stays low, whatever the other inputs are.
- R2: With `unit_en` high and `cfg_aborted` high, `out_perm` is 0 and no event is pushed. This holds even when a configuration fault or a walk error is also present.
- R3: With the unit enabled, not aborted and `cfg_fault` non-zero, `out_perm` is 0. An event is pushed whose `evt_type` equals `cfg_fault`, with `evt_class` 0 and `evt_addr2` 0. The walk result is ignored.
- R4: With the unit enabled, not aborted, `cfg_fault` zero and `walk_err` 0 (no error), `out_perm` equals `req_flags` and no event is pushed.
- R5: `walk_err` 1 (external abort during the walk) always pushes event code 0x0B, whatever `rec_faults` is. The event has `evt_class` 1 and `evt_addr2` equal to `walk_addr`, and `out_perm` is 0.
- R6: `walk_err` values map to these event codes: 2 (translation) to 0x10, 3 (address size) to 0x11, 4 (access) to 0x12, 5 (permission) to 0x13. The reserved values 6 and 7 are treated as translation. `out_perm` is 0 in every one of these cases. The event is pushed only when `rec_faults` is 1.
- R7: Every pushed event carries `evt_addr` equal to `req_addr` and `evt_rnw` equal to bit 0 of `req_flags`. Bit 0 is the read permission and bit 1 the write permission.
- R8: Each cycle with `in_valid` high gives exactly one `out_valid` pulse in the next cycle, with at most one event. With `in_valid` low, neither `out_valid` nor `evt_push` rises in the next cycle.
- R9: While `rst_n` is low and right after it, `out_valid` and `evt_push` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Translation outcome present this cycle |
| unit_en | input | 1 | Translation unit enabled |
| cfg_aborted | input | 1 | Configuration requested a silent abort |
| cfg_fault | input | EVT_W | Configuration fault event code, 0 = none |
| walk_err | input | 3 | Page-walk error class |
| walk_addr | input | ADDR_W | Address of the walk access that failed |
| req_addr | input | ADDR_W | Request input address |
| req_flags | input | PERM_W | Requested access, bit 0 read, bit 1 write |
| rec_faults | input | 1 | Record ordinary walk faults |
| out_valid | output | 1 | Result valid |
| out_perm | output | PERM_W | Granted permission, 0 = none |
| evt_push | output | 1 | Push one event record |
| evt_type | output | EVT_W | Event code |
| evt_addr | output | ADDR_W | Faulting request address |
| evt_rnw | output | 1 | Read/write bit of the event |
| evt_class | output | CLASS_W | Fault class, 1 for walk external abort |
| evt_addr2 | output | ADDR_W | Walk address for walk external abort |

## Verification
The hard cases are the ones where several fault sources are present at once. Only the highest-priority source may decide the result: disabled over aborted, aborted over configuration fault, configuration fault over walk error. To reach them, the stimulus stacks a walk abort and a configuration code under a disabled unit and under an aborted configuration, then lays a walk abort under a configuration fault. It also runs each ordinary walk fault with record-faults both low and high. All of this is driven back to back, so a lost or doubled event would shift every following comparison.

// File: rtl/tfem_pkg.sv
package tfem_pkg;
   localparam int WALK_ERR_W = 3;

   // Page-walk error classes as seen on walk_err
   localparam logic [WALK_ERR_W-1:0] WE_NONE      = 3'd0;
   localparam logic [WALK_ERR_W-1:0] WE_EXT_ABORT = 3'd1;
   localparam logic [WALK_ERR_W-1:0] WE_XLATE     = 3'd2;
   localparam logic [WALK_ERR_W-1:0] WE_ADDR_SIZE = 3'd3;
   localparam logic [WALK_ERR_W-1:0] WE_ACCESS    = 3'd4;
   localparam logic [WALK_ERR_W-1:0] WE_PERM      = 3'd5;

   // Event codes emitted for walk errors (need at least 5 bits)
   localparam logic [7:0] EVC_WALK_ABORT = 8'h0B;
   localparam logic [7:0] EVC_XLATE      = 8'h10;
   localparam logic [7:0] EVC_ADDR_SIZE  = 8'h11;
   localparam logic [7:0] EVC_ACCESS     = 8'h12;
   localparam logic [7:0] EVC_PERM       = 8'h13;
   localparam int         EVC_MIN_W      = 5;
endpackage

// File: rtl/tfem_classify.sv
module tfem_classify
   import tfem_pkg::*;
#(
   parameter int EVT_W = 8
) (
   input  logic                  unit_en,
   input  logic                  cfg_aborted,
   input  logic [EVT_W-1:0]      cfg_fault,
   input  logic [WALK_ERR_W-1:0] walk_err,
   input  logic                  rec_faults,
   output logic                  grant,
   output logic                  push,
   output logic                  walk_abort,
   output logic [EVT_W-1:0]      code
);
   // Priority: disabled, aborted, configuration fault, walk result
   always_comb begin
      grant      = 1'b0;
      push       = 1'b0;
      walk_abort = 1'b0;
      code       = '0;
      if (!unit_en) begin
         grant = 1'b1;
      end else if (cfg_aborted) begin
         grant = 1'b0;
      end else if (cfg_fault != '0) begin
         push = 1'b1;
         code = cfg_fault;
      end else begin
         unique case (walk_err)
            WE_NONE: grant = 1'b1;
            WE_EXT_ABORT: begin
               push       = 1'b1;
               walk_abort = 1'b1;
               code       = EVT_W'(EVC_WALK_ABORT);
            end
            WE_ADDR_SIZE: begin
               push = rec_faults;
               code = EVT_W'(EVC_ADDR_SIZE);
            end
            WE_ACCESS: begin
               push = rec_faults;
               code = EVT_W'(EVC_ACCESS);
            end
            WE_PERM: begin
               push = rec_faults;
               code = EVT_W'(EVC_PERM);
            end
            default: begin
               push = rec_faults;
               code = EVT_W'(EVC_XLATE);
            end
         endcase
      end
   end
endmodule

// File: rtl/tfem_record.sv
module tfem_record #(
   parameter int ADDR_W    = 48,
   parameter int CLASS_W   = 2,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic               push,
   input  logic               walk_abort,
   input  logic               rnw_bit,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [ADDR_W-1:0]  walk_addr,
   output logic [ADDR_W-1:0]  rec_addr,
   output logic               rec_rnw,
   output logic [CLASS_W-1:0] rec_class,
   output logic [ADDR_W-1:0]  rec_addr2
);
   localparam logic [CLASS_W-1:0] CLASS_WALK = CLASS_W'(1);

   logic [CLASS_W-1:0] class_raw;
   logic [ADDR_W-1:0]  addr2_raw;

   assign class_raw = walk_abort ? CLASS_WALK : '0;
   assign addr2_raw = walk_abort ? walk_addr  : '0;

   generate
      if (ZERO_IDLE) begin : g_gated
         // Fields read as zero when no event is pushed
         assign rec_addr  = push ? req_addr  : '0;
         assign rec_rnw   = push & rnw_bit;
         assign rec_class = push ? class_raw : '0;
         assign rec_addr2 = push ? addr2_raw : '0;
      end else begin : g_free
         assign rec_addr  = req_addr;
         assign rec_rnw   = rnw_bit;
         assign rec_class = class_raw;
         assign rec_addr2 = addr2_raw;
      end
   endgenerate
endmodule

// File: rtl/tfem_out_reg.sv
module tfem_out_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d,
   output logic         q_valid,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q       <= '0;
      end else begin
         q_valid <= d_valid;
         q       <= d_valid ? d : '0;
      end
   end
endmodule

// File: rtl/tfem_fault_mapper.sv
module tfem_fault_mapper
   import tfem_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int EVT_W     = 8,
   parameter int CLASS_W   = 2,
   parameter int PERM_W    = 2,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  unit_en,
   input  logic                  cfg_aborted,
   input  logic [EVT_W-1:0]      cfg_fault,
   input  logic [WALK_ERR_W-1:0] walk_err,
   input  logic [ADDR_W-1:0]     walk_addr,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [PERM_W-1:0]     req_flags,
   input  logic                  rec_faults,
   output logic                  out_valid,
   output logic [PERM_W-1:0]     out_perm,
   output logic                  evt_push,
   output logic [EVT_W-1:0]      evt_type,
   output logic [ADDR_W-1:0]     evt_addr,
   output logic                  evt_rnw,
   output logic [CLASS_W-1:0]    evt_class,
   output logic [ADDR_W-1:0]     evt_addr2
);
   localparam int PACK_W = PERM_W + 1 + EVT_W + ADDR_W + 1 + CLASS_W + ADDR_W;

   initial begin
      assert (EVT_W >= EVC_MIN_W) else $error("EVT_W too narrow for event codes");
      assert (PERM_W >= 1)        else $error("PERM_W must hold the read bit");
      assert (CLASS_W >= 1)       else $error("CLASS_W must be at least 1");
      assert (ADDR_W >= 12)       else $error("ADDR_W below a page offset");
   end

   logic               grant, push, walk_abort;
   logic [EVT_W-1:0]   code;
   logic [ADDR_W-1:0]  rec_addr, rec_addr2;
   logic               rec_rnw;
   logic [CLASS_W-1:0] rec_class;
   logic [PERM_W-1:0]  perm_d;
   logic [PACK_W-1:0]  pack_d, pack_q;

   tfem_classify #(.EVT_W(EVT_W)) u_classify (
      .unit_en    (unit_en),
      .cfg_aborted(cfg_aborted),
      .cfg_fault  (cfg_fault),
      .walk_err   (walk_err),
      .rec_faults (rec_faults),
      .grant      (grant),
      .push       (push),
      .walk_abort (walk_abort),
      .code       (code)
   );

   tfem_record #(
      .ADDR_W   (ADDR_W),
      .CLASS_W  (CLASS_W),
      .ZERO_IDLE(ZERO_IDLE)
   ) u_record (
      .push      (push),
      .walk_abort(walk_abort),
      .rnw_bit   (req_flags[0]),
      .req_addr  (req_addr),
      .walk_addr (walk_addr),
      .rec_addr  (rec_addr),
      .rec_rnw   (rec_rnw),
      .rec_class (rec_class),
      .rec_addr2 (rec_addr2)
   );

   assign perm_d = grant ? req_flags : '0;
   assign pack_d = {perm_d, push, (push ? code : '0), rec_addr, rec_rnw, rec_class, rec_addr2};

   tfem_out_reg #(.W(PACK_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_valid(in_valid),
      .d      (pack_d),
      .q_valid(out_valid),
      .q      (pack_q)
   );

   assign {out_perm, evt_push, evt_type, evt_addr, evt_rnw, evt_class, evt_addr2} = pack_q;
endmodule

// File: rtl/tfem_fault_mapper_chk.sv
module tfem_fault_mapper_chk #(
   parameter int ADDR_W  = 48,
   parameter int EVT_W   = 8,
   parameter int CLASS_W = 2,
   parameter int PERM_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               unit_en,
   input logic               cfg_aborted,
   input logic [EVT_W-1:0]   cfg_fault,
   input logic [2:0]         walk_err,
   input logic [ADDR_W-1:0]  walk_addr,
   input logic [PERM_W-1:0]  req_flags,
   input logic               out_valid,
   input logic [PERM_W-1:0]  out_perm,
   input logic               evt_push,
   input logic               evt_rnw,
   input logic [CLASS_W-1:0] evt_class,
   input logic [ADDR_W-1:0]  evt_addr2
);
   AST_PUSH_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      evt_push |-> out_valid);  // R8
   AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);  // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !evt_push);  // R8
   AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !unit_en |=> !evt_push && out_perm == $past(req_flags));  // R1
   AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && unit_en && cfg_aborted |=> !evt_push && out_perm == '0);  // R2
   AST_CFG_FAULT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && unit_en && !cfg_aborted && cfg_fault != '0 |=> evt_push && evt_class == '0);  // R3
   AST_WALK_ABORT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && unit_en && !cfg_aborted && cfg_fault == '0 && walk_err == 3'd1
      |=> evt_push && evt_class == CLASS_W'(1) && evt_addr2 == $past(walk_addr));  // R5
   AST_EVENT_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
      evt_push |-> out_perm == '0);  // R6
   AST_RNW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> !evt_push || evt_rnw == $past(req_flags[0]));  // R7
endmodule

bind tfem_fault_mapper tfem_fault_mapper_chk #(
   .ADDR_W (ADDR_W),
   .EVT_W  (EVT_W),
   .CLASS_W(CLASS_W),
   .PERM_W (PERM_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .unit_en    (unit_en),
   .cfg_aborted(cfg_aborted),
   .cfg_fault  (cfg_fault),
   .walk_err   (walk_err),
   .walk_addr  (walk_addr),
   .req_flags  (req_flags),
   .out_valid  (out_valid),
   .out_perm   (out_perm),
   .evt_push   (evt_push),
   .evt_rnw    (evt_rnw),
   .evt_class  (evt_class),
   .evt_addr2  (evt_addr2)
);

// File: tb/tfem_fault_mapper_test.sv
`timescale 1ns/1ps
module tfem_fault_mapper_test;
   localparam int ADDR_W  = 48;
   localparam int EVT_W   = 8;
   localparam int CLASS_W = 2;
   localparam int PERM_W  = 2;

   typedef struct {
      string              tag;
      logic [PERM_W-1:0]  perm;
      logic               push;
      logic [EVT_W-1:0]   etype;
      logic [ADDR_W-1:0]  addr;
      logic               rnw;
      logic [CLASS_W-1:0] cls;
      logic [ADDR_W-1:0]  addr2;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               unit_en = 1'b0;
   logic               cfg_aborted = 1'b0;
   logic [EVT_W-1:0]   cfg_fault = '0;
   logic [2:0]         walk_err = '0;
   logic [ADDR_W-1:0]  walk_addr = '0;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic [PERM_W-1:0]  req_flags = '0;
   logic               rec_faults = 1'b0;
   logic               out_valid;
   logic [PERM_W-1:0]  out_perm;
   logic               evt_push;
   logic [EVT_W-1:0]   evt_type;
   logic [ADDR_W-1:0]  evt_addr;
   logic               evt_rnw;
   logic [CLASS_W-1:0] evt_class;
   logic [ADDR_W-1:0]  evt_addr2;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #4 clk = ~clk;

   tfem_fault_mapper #(
      .ADDR_W(ADDR_W), .EVT_W(EVT_W), .CLASS_W(CLASS_W), .PERM_W(PERM_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .unit_en(unit_en),
      .cfg_aborted(cfg_aborted), .cfg_fault(cfg_fault), .walk_err(walk_err),
      .walk_addr(walk_addr), .req_addr(req_addr), .req_flags(req_flags),
      .rec_faults(rec_faults), .out_valid(out_valid), .out_perm(out_perm),
      .evt_push(evt_push), .evt_type(evt_type), .evt_addr(evt_addr),
      .evt_rnw(evt_rnw), .evt_class(evt_class), .evt_addr2(evt_addr2)
   );

   function automatic exp_t model(string tag, bit en, bit ab, logic [EVT_W-1:0] cf,
                                  logic [2:0] we, logic [ADDR_W-1:0] wa,
                                  logic [ADDR_W-1:0] ra, logic [PERM_W-1:0] fl, bit rec);
      exp_t e;
      e.tag = tag; e.perm = '0; e.push = 1'b0; e.etype = '0;
      e.addr = ra; e.rnw = fl[0]; e.cls = '0; e.addr2 = '0;
      if (!en)           e.perm = fl;
      else if (ab)       e.perm = '0;
      else if (cf != 0)  begin e.push = 1'b1; e.etype = cf; end
      else begin
         case (we)
            3'd0: e.perm = fl;
            3'd1: begin e.push = 1'b1; e.etype = 8'h0B; e.cls = 2'd1; e.addr2 = wa; end
            3'd3: begin e.push = rec; e.etype = 8'h11; end
            3'd4: begin e.push = rec; e.etype = 8'h12; end
            3'd5: begin e.push = rec; e.etype = 8'h13; end
            default: begin e.push = rec; e.etype = 8'h10; end
         endcase
      end
      return e;
   endfunction

   task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   task automatic drive(string tag, bit en, bit ab, logic [EVT_W-1:0] cf, logic [2:0] we,
                        logic [ADDR_W-1:0] wa, logic [ADDR_W-1:0] ra,
                        logic [PERM_W-1:0] fl, bit rec);
      @(negedge clk);
      in_valid = 1'b1; unit_en = en; cfg_aborted = ab; cfg_fault = cf;
      walk_err = we; walk_addr = wa; req_addr = ra; req_flags = fl; rec_faults = rec;
      @(posedge clk);
      #1;
      sb.push_back(model(tag, en, ab, cf, we, wa, ra, fl, rec));
   endtask

   task automatic idle(int n);
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         n_checks++;
         if (out_valid || evt_push) fail("R8", "idle out_valid/evt_push", {out_valid, evt_push}, 0);
      end
   endtask

   // Monitor: pops one expectation per result
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (out_valid) begin
               if (sb.size() == 0) begin
                  n_checks++;
                  fail("R8", "unexpected out_valid", 1, 0);
               end else begin
                  exp_t e;
                  bit   bad;
                  e = sb.pop_front();
                  n_checks++;
                  bad = 1'b0;
                  if (out_perm !== e.perm) begin bad = 1'b1; fail(e.tag, "out_perm", out_perm, e.perm); end
                  if (evt_push !== e.push) begin bad = 1'b1; fail(e.tag, "evt_push", evt_push, e.push); end
                  if (!bad && e.push) begin
                     if (evt_type  !== e.etype) fail(e.tag, "evt_type", evt_type, e.etype);
                     if (evt_addr  !== e.addr)  fail(e.tag, "evt_addr", evt_addr, e.addr);
                     if (evt_rnw   !== e.rnw)   fail(e.tag, "evt_rnw", evt_rnw, e.rnw);
                     if (evt_class !== e.cls)   fail(e.tag, "evt_class", evt_class, e.cls);
                     if (evt_addr2 !== e.addr2) fail(e.tag, "evt_addr2", evt_addr2, e.addr2);
                  end
               end
            end else if (sb.size() != 0) begin
               n_checks++;
               fail("R8", "missing out_valid", 0, 1);
               void'(sb.pop_front());
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(8 * 5000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      n_checks++;
      if (out_valid || evt_push) fail("R9", "in reset", {out_valid, evt_push}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (out_valid || evt_push) fail("R9", "after reset", {out_valid, evt_push}, 0);

      // R1: disabled unit passes through even with faults stacked
      drive("R1_plain", 0, 0, 8'h00, 3'd0, 48'h0, 48'h1000, 2'b11, 1);
      drive("R1_stack", 0, 1, 8'h05, 3'd1, 48'hBEEF0, 48'h2000, 2'b10, 1);
      // R2: aborted configuration is silent
      drive("R2_cfg", 1, 1, 8'h05, 3'd0, 48'h0, 48'h3000, 2'b11, 1);
      drive("R2_walk", 1, 1, 8'h00, 3'd1, 48'hAAA0, 48'h3040, 2'b01, 1);
      // R3: configuration fault wins over walk abort
      drive("R3_code", 1, 0, 8'h05, 3'd1, 48'h77770, 48'h4000, 2'b01, 0);
      drive("R3_code2", 1, 0, 8'h0A, 3'd2, 48'h0, 48'h4400, 2'b10, 1);
      // R4: clean walk grants the request
      drive("R4_rw", 1, 0, 8'h00, 3'd0, 48'h0, 48'h5000, 2'b11, 0);
      drive("R4_rd", 1, 0, 8'h00, 3'd0, 48'h0, 48'h5008, 2'b01, 1);
      // R5: walk external abort always recorded
      drive("R5_norec", 1, 0, 8'h00, 3'd1, 48'hABCDE000, 48'h6000, 2'b01, 0);
      drive("R5_rec", 1, 0, 8'h00, 3'd1, 48'h123456780, 48'h6100, 2'b10, 1);
      // R6: ordinary walk faults gated by rec_faults
      for (int w = 2; w < 8; w++) begin
         drive("R6_rec", 1, 0, 8'h00, 3'(w), 48'h0, 48'h7000 + 48'(w), 2'b01, 1);
         drive("R6_norec", 1, 0, 8'h00, 3'(w), 48'h0, 48'h7100 + 48'(w), 2'b11, 0);
      end
      // R7: read/write bit taken from flag bit 0
      drive("R7_w", 1, 0, 8'h00, 3'd5, 48'h0, 48'hFFFF_FFFF_F000, 2'b10, 1);
      drive("R7_r", 1, 0, 8'h00, 3'd4, 48'h0, 48'h8000_0000_0000, 2'b01, 1);
      // R8: gap then more back-to-back
      idle(3);
      drive("R8_after_gap", 1, 0, 8'h00, 3'd3, 48'h0, 48'h9000, 2'b11, 1);
      drive("R8_b2b", 0, 0, 8'h00, 3'd0, 48'h0, 48'h9100, 2'b00, 0);
      idle(3);

      n_checks++;
      if (sb.size() != 0) fail("R8", "leftover expectations", sb.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule